// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Access

This peripheral watches for software that has stopped responding. A down-counter moves by one on every cycle where the watchdog tick enable is high. The first time it runs out, the block sets an interrupt flag and starts counting again from the reload value. If it runs out a second time while that flag is still set, the block latches a reset request and halts the counter. Software keeps the system alive by clearing the interrupt, which also restarts the count from the reload value.

All registers sit behind an APB slave with zero wait states. A lock register protects the block against stray writes: while it is locked, writes to every other register are dropped. A test mode lets software drive both outputs directly. A build parameter selects an alternate variant. In that variant the interrupt enable cannot be cleared once it is set, and the test registers are not present.

Top module: `dual_stage_wdt`

## Requirements
- R1: After the synchronous reset, the control, status, lock and test registers are zero, both outputs are low, and the reload value and counter both read 0xFFFFFFFF with the counter running.
- R2: The counter decrements only on cycles where `tick_en` is high and the counter is running. With `tick_en` low it holds its value.
- R3: A decrement from 1 to 0 while the raw interrupt flag is clear sets that flag. The next tick reloads the counter from the reload value.
- R4: A decrement from 1 to 0 while the raw flag is already set latches the reset status and halts the counter at 0. Only a reset clears the reset status.
- R5: A write to word offset 0x000 sets the reload value, loads the counter with it at once, and restarts a halted counter.
- R6: A write of any data to offset 0x00C clears the raw flag and reloads the counter from the reload value.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R8: Control register 0x008 stores only bit 0 (interrupt enable) and bit 1 (reset enable); its other bits read zero. Outside test mode, `irq_o` equals the raw flag AND bit 0, and `rst_req_o` equals the reset status AND bit 1. Offset 0x014 reads the same masked interrupt value.
- R9: With bit 0 of test control register 0xF00 set, bit 0 of test output register 0xF04 drives `rst_req_o` and bit 1 drives `irq_o`.
- R10: Reads return the reload value (0x000), the counter (0x004), control (0x008), the raw flag in bit 0 (0x010), the masked flag in bit 0 (0x014), lock (0xC00) and test control (0xF00). Reads of 0x00C, 0xF04 and unmapped offsets return zero. Writes to 0x004, 0x010 and 0x014 change nothing.
- R11: With `ALT_VARIANT=1`, writes to control are dropped once the interrupt enable is set. The test registers are absent: their writes are ignored, they read zero, and they never steer the outputs.
- R12: `pready` is always 1 and `pslverr` always 0. A register write in the same cycle as a tick overrides that tick's counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Watchdog count enable, one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address; bits [11:2] select the register |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq_o | output | 1 | Level interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
Directed sequences drive a short reload through one expiry and then a second one. They separate the interrupt stage from the reset stage, check the wrap on the tick after the first expiry, and check that the counter stays halted after the second. Lock, test-mode and read-only sequences check that dropped writes leave the read-back state unchanged. A tick held high across a load write checks which action wins in that cycle. A seeded random mix then interleaves loads, clears, control, lock and test writes with random ticks, and compares every read and both outputs on every cycle against a bench model. This exposes priority or ordering faults that the directed cases miss. A second instance built as the alternate variant is checked for the sticky enable and for the missing test registers.

// File: rtl/dswdt_pkg.sv
package dswdt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 10;

    // word indices (paddr[11:2])
    localparam logic [IDX_W-1:0] IX_LOAD  = 10'h000;
    localparam logic [IDX_W-1:0] IX_VALUE = 10'h001;
    localparam logic [IDX_W-1:0] IX_CTRL  = 10'h002;
    localparam logic [IDX_W-1:0] IX_ICLR  = 10'h003;
    localparam logic [IDX_W-1:0] IX_RAW   = 10'h004;
    localparam logic [IDX_W-1:0] IX_MSK   = 10'h005;
    localparam logic [IDX_W-1:0] IX_LOCK  = 10'h300;
    localparam logic [IDX_W-1:0] IX_TCTL  = 10'h3C0;
    localparam logic [IDX_W-1:0] IX_TOUT  = 10'h3C1;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;   // bit 1
        logic irq_en;   // bit 0
    } ctl_t;

    typedef struct packed {
        logic irq;      // bit 1
        logic rst;      // bit 0
    } tout_t;

    typedef struct packed {
        logic load;
        logic iclr;
    } cmd_t;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_DEC,
        STEP_WRAP,
        STEP_EXP_FIRST,
        STEP_EXP_SECOND
    } step_e;

    function automatic logic key_match(input logic [DATA_W-1:0] d);
        return d == UNLOCK_KEY;
    endfunction

    function automatic logic [DATA_W-1:0] bit_word(input logic b);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = b;
        return w;
    endfunction

endpackage

// File: rtl/dswdt_core.sv
module dswdt_core
    import dswdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cmd_t             cmd,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload,
    output logic             raw_flag,
    output logic             rst_stat
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic  running;
    step_e step;

    always_comb begin
        step = STEP_IDLE;
        if (tick && running) begin
            if (cnt == '0)
                step = STEP_WRAP;
            else if (cnt == CNT_ONE)
                step = raw_flag ? STEP_EXP_SECOND : STEP_EXP_FIRST;
            else
                step = STEP_DEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload   <= '1;
            cnt      <= '1;
            running  <= 1'b1;
            raw_flag <= 1'b0;
            rst_stat <= 1'b0;
        end else if (cmd.load) begin
            reload  <= ld_val;
            cnt     <= ld_val;
            running <= 1'b1;
        end else if (cmd.iclr) begin
            raw_flag <= 1'b0;
            cnt      <= reload;
        end else begin
            unique case (step)
                STEP_DEC:       cnt <= cnt - CNT_ONE;
                STEP_WRAP:      cnt <= reload;
                STEP_EXP_FIRST: begin
                    cnt      <= '0;
                    raw_flag <= 1'b1;
                end
                STEP_EXP_SECOND: begin
                    cnt      <= '0;
                    rst_stat <= 1'b1;
                    running  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cmd.load && !cmd.iclr) |=> $stable(cnt));

    assert_first_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && running && cnt == CNT_ONE && !raw_flag && !cmd.load && !cmd.iclr)
        |=> raw_flag);

    assert_second_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && running && cnt == CNT_ONE && raw_flag && !cmd.load && !cmd.iclr)
        |=> (rst_stat && !running && cnt == '0));

    assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        rst_stat |=> rst_stat);

    assert_load_restart_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (cnt == $past(ld_val) && running));

    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.iclr && !cmd.load) |=> !raw_flag);

endmodule

// File: rtl/dswdt_regs.sv
module dswdt_regs
    import dswdt_pkg::*;
#(
    parameter bit          ALT_VARIANT = 1'b0,
    parameter int unsigned CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  reload,
    input  logic              raw_flag,
    output logic [DATA_W-1:0] prdata,
    output cmd_t              cmd,
    output logic [CNT_W-1:0]  ld_val,
    output ctl_t              ctrl,
    output logic              test_en,
    output tout_t             tout
);

    logic lock;
    logic wr_any;
    logic wr_open;
    logic ctrl_we;
    logic [DATA_W-1:0] cnt_ext;
    logic [DATA_W-1:0] reload_ext;

    assign wr_any  = psel && penable && pwrite;
    assign wr_open = wr_any && !lock;
    assign ctrl_we = wr_open && (widx == IX_CTRL) && !(ALT_VARIANT && ctrl.irq_en);

    assign cmd.load = wr_open && (widx == IX_LOAD);
    assign cmd.iclr = wr_open && (widx == IX_ICLR);
    assign ld_val   = pwdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= 1'b0;
            ctrl <= '0;
        end else begin
            if (wr_any && widx == IX_LOCK)
                lock <= !key_match(pwdata);
            if (ctrl_we)
                ctrl <= ctl_t'(pwdata[1:0]);
        end
    end

    generate
        if (ALT_VARIANT == 1'b0) begin : g_test
            logic  tctl_q;
            tout_t tout_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tctl_q <= 1'b0;
                    tout_q <= '0;
                end else begin
                    if (wr_open && widx == IX_TCTL)
                        tctl_q <= pwdata[0];
                    if (wr_open && widx == IX_TOUT)
                        tout_q <= tout_t'(pwdata[1:0]);
                end
            end
            assign test_en = tctl_q;
            assign tout    = tout_q;
        end else begin : g_no_test
            assign test_en = 1'b0;
            assign tout    = '0;
        end
    endgenerate

    always_comb begin
        cnt_ext    = '0;
        reload_ext = '0;
        cnt_ext[CNT_W-1:0]    = cnt;
        reload_ext[CNT_W-1:0] = reload;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (widx)
                IX_LOAD:  prdata = reload_ext;
                IX_VALUE: prdata = cnt_ext;
                IX_CTRL:  prdata = {{(DATA_W-2){1'b0}}, ctrl};
                IX_RAW:   prdata = bit_word(raw_flag);
                IX_MSK:   prdata = bit_word(raw_flag && ctrl.irq_en);
                IX_LOCK:  prdata = bit_word(lock);
                IX_TCTL:  prdata = bit_word(test_en);
                default:  prdata = '0;
            endcase
        end
    end

    assert_locked_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
        (lock && wr_any && widx == IX_CTRL) |=> $stable(ctrl));

    assert_locked_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        lock |-> (!cmd.load && !cmd.iclr));

    assert_key_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_any && widx == IX_LOCK && pwdata == UNLOCK_KEY) |=> !lock);

    generate
        if (ALT_VARIANT) begin : g_alt_chk
            assert_sticky_enable_R11: assert property (@(posedge clk) disable iff (rst)
                ctrl.irq_en |=> ctrl.irq_en);
        end
    endgenerate

endmodule

// File: rtl/dswdt_outsel.sv
module dswdt_outsel
    import dswdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  tout_t tout,
    input  ctl_t  ctrl,
    input  logic  raw_flag,
    input  logic  rst_stat,
    output logic  irq_o,
    output logic  rst_req_o
);

    always_comb begin
        if (test_en) begin
            irq_o     = tout.irq;
            rst_req_o = tout.rst;
        end else begin
            irq_o     = raw_flag && ctrl.irq_en;
            rst_req_o = rst_stat && ctrl.rst_en;
        end
    end

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !ctrl.irq_en) |-> !irq_o);

    assert_rst_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !rst_stat) |-> !rst_req_o);

endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
    import dswdt_pkg::*;
#(
    parameter bit          ALT_VARIANT = 1'b0,
    parameter int unsigned CNT_W       = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    output logic        irq_o,
    output logic        rst_req_o
);

    cmd_t             cmd;
    ctl_t             ctrl;
    tout_t            tout;
    logic             test_en;
    logic             raw_flag;
    logic             rst_stat;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] ld_val;
    logic             unused_addr_lsb;

    assign unused_addr_lsb = ^paddr[1:0];
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    dswdt_regs #(
        .ALT_VARIANT(ALT_VARIANT),
        .CNT_W      (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .widx    (paddr[11:2]),
        .pwdata  (pwdata),
        .cnt     (cnt),
        .reload  (reload),
        .raw_flag(raw_flag),
        .prdata  (prdata),
        .cmd     (cmd),
        .ld_val  (ld_val),
        .ctrl    (ctrl),
        .test_en (test_en),
        .tout    (tout)
    );

    dswdt_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .cmd     (cmd),
        .ld_val  (ld_val),
        .cnt     (cnt),
        .reload  (reload),
        .raw_flag(raw_flag),
        .rst_stat(rst_stat)
    );

    dswdt_outsel u_out (
        .clk      (clk),
        .rst      (rst),
        .test_en  (test_en),
        .tout     (tout),
        .ctrl     (ctrl),
        .raw_flag (raw_flag),
        .rst_stat (rst_stat),
        .irq_o    (irq_o),
        .rst_req_o(rst_req_o)
    );

endmodule

// File: tb/sim_dual_stage_wdt.sv
`timescale 1ns/1ps
module sim_dual_stage_wdt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata0, prdata1;
    logic        pready0, pslverr0, irq0, rq0;
    logic        pready1, pslverr1, irq1, rq1;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;
    bit rnd_tick = 1'b0;

    always #2 clk = ~clk;

    dual_stage_wdt #(.ALT_VARIANT(1'b0)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata0),
        .pready(pready0), .pslverr(pslverr0), .irq_o(irq0), .rst_req_o(rq0));

    dual_stage_wdt #(.ALT_VARIANT(1'b1)) u1 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata1),
        .pready(pready1), .pslverr(pslverr1), .irq_o(irq1), .rst_req_o(rq1));

    // ---------------- bench model of the standard variant ----------------
    logic [31:0] m_reload = '1, m_cnt = '1;
    logic        m_run = 1'b1, m_raw = 1'b0, m_rs = 1'b0, m_lock = 1'b0;
    logic [1:0]  m_ctrl = '0, m_tout = '0;
    logic        m_tctl = 1'b0;

    always @(posedge clk) begin
        logic [9:0] ix;
        bit         took;
        ix   = paddr[11:2];
        took = 1'b0;
        if (rst) begin
            m_reload = '1; m_cnt = '1; m_run = 1'b1; m_raw = 1'b0; m_rs = 1'b0;
            m_lock = 1'b0; m_ctrl = '0; m_tout = '0; m_tctl = 1'b0;
        end else begin
            if (psel && penable && pwrite) begin
                if (ix == 10'h300) m_lock = (pwdata != 32'h1ACCE551);
                else if (!m_lock) begin
                    case (ix)
                        10'h000: begin m_reload = pwdata; m_cnt = pwdata; m_run = 1'b1; took = 1'b1; end
                        10'h002: m_ctrl = pwdata[1:0];
                        10'h003: begin m_raw = 1'b0; m_cnt = m_reload; took = 1'b1; end
                        10'h3C0: m_tctl = pwdata[0];
                        10'h3C1: m_tout = pwdata[1:0];
                        default: ;
                    endcase
                end
            end
            if (!took && tick_en && m_run) begin
                if (m_cnt == 0) m_cnt = m_reload;
                else if (m_cnt == 1) begin
                    m_cnt = 0;
                    if (m_raw) begin m_rs = 1'b1; m_run = 1'b0; end
                    else m_raw = 1'b1;
                end else m_cnt = m_cnt - 1;
            end
        end
    end

    function automatic logic m_irq();
        return m_tctl ? m_tout[1] : (m_raw & m_ctrl[0]);
    endfunction
    function automatic logic m_rq();
        return m_tctl ? m_tout[0] : (m_rs & m_ctrl[1]);
    endfunction
    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a[11:2])
            10'h000: return m_reload;
            10'h001: return m_cnt;
            10'h002: return {30'b0, m_ctrl};
            10'h004: return {31'b0, m_raw};
            10'h005: return {31'b0, m_raw & m_ctrl[0]};
            10'h300: return {31'b0, m_lock};
            10'h3C0: return {31'b0, m_tctl};
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R8 irq_o vs model", {31'b0, irq0}, {31'b0, m_irq()});
            chk("R4 rst_req_o vs model", {31'b0, rq0}, {31'b0, m_rq()});
        end
    end

    task automatic step();
        @(negedge clk);
        if (rnd_tick) tick_en = 1'($urandom_range(0, 1));
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step();
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        step();
        penable = 1'b1;
        step();
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        step();
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        step();
        penable = 1'b1;
        #1;
        d0 = prdata0;
        d1 = prdata1;
        step();
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n);
        step();
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        step();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r0, r1, v;
        void'($urandom(32'h00C0FFEE));
        do_reset();
        cmp_on = 1'b1;

        // R1 reset state
        rd(12'h000, r0, r1); chk("R1 load after reset", r0, 32'hFFFF_FFFF);
        rd(12'h004, r0, r1); chk("R1 value after reset (R2 no tick)", r0, 32'hFFFF_FFFF);
        rd(12'hC00, r0, r1); chk("R1 lock after reset", r0, 0);
        rd(12'h008, r0, r1); chk("R1 control after reset", r0, 0);
        chk("R1 irq low", {31'b0, irq0}, 0);
        chk("R12 pready", {31'b0, pready0}, 1);
        chk("R12 pslverr", {31'b0, pslverr0}, 0);

        // R5 load, R2/R3/R4 two-stage expiry
        wr(12'h008, 32'h3);
        wr(12'h000, 32'd5);
        rd(12'h004, r0, r1); chk("R5 counter loaded", r0, 5);
        ticks(4);
        rd(12'h004, r0, r1); chk("R2 four ticks", r0, 1);
        chk("R3 no irq yet", {31'b0, irq0}, 0);
        ticks(1);
        chk("R3 irq after first expiry", {31'b0, irq0}, 1);
        rd(12'h010, r0, r1); chk("R3 raw flag", r0, 1);
        rd(12'h014, r0, r1); chk("R8 masked flag", r0, 1);
        ticks(1);
        rd(12'h004, r0, r1); chk("R3 reload on next tick", r0, 5);
        ticks(5);
        chk("R4 reset request", {31'b0, rq0}, 1);
        ticks(3);
        rd(12'h004, r0, r1); chk("R4 counter halted", r0, 0);

        // R6 clear
        wr(12'h00C, 32'hDEAD_BEEF);
        chk("R6 irq cleared", {31'b0, irq0}, 0);
        rd(12'h004, r0, r1); chk("R6 counter reloaded", r0, 5);
        chk("R4 reset status sticky", {31'b0, rq0}, 1);
        wr(12'h000, 32'd3);
        ticks(2);
        rd(12'h004, r0, r1); chk("R5 load restarts halted counter", r0, 1);

        // R7 lock
        wr(12'hC00, 32'h0);
        rd(12'hC00, r0, r1); chk("R7 lock reads 1", r0, 1);
        wr(12'h008, 32'h0);
        rd(12'h008, r0, r1); chk("R7 control write ignored", r0, 3);
        wr(12'h000, 32'd9);
        rd(12'h000, r0, r1); chk("R7 load write ignored", r0, 3);
        wr(12'hC00, 32'h1ACC_E551);
        rd(12'hC00, r0, r1); chk("R7 unlocked", r0, 0);

        // R8 control bits
        wr(12'h008, 32'hFFFF_FFFC);
        rd(12'h008, r0, r1); chk("R8 only two bits stored", r0, 0);
        chk("R8 reset masked by enable", {31'b0, rq0}, 0);

        // R9 test mode
        wr(12'hF00, 32'h1);
        wr(12'hF04, 32'h2);
        chk("R9 test irq", {31'b0, irq0}, 1);
        chk("R9 test rst", {31'b0, rq0}, 0);
        wr(12'hF04, 32'h1);
        chk("R9 test irq off", {31'b0, irq0}, 0);
        chk("R9 test rst on", {31'b0, rq0}, 1);
        rd(12'hF00, r0, r1); chk("R10 test control readable", r0, 1);
        wr(12'hF00, 32'h0);

        // R10 read map
        rd(12'h00C, r0, r1); chk("R10 clear reads zero", r0, 0);
        rd(12'hF04, r0, r1); chk("R10 test output reads zero", r0, 0);
        rd(12'h800, r0, r1); chk("R10 unmapped reads zero", r0, 0);
        rd(12'h004, v, r1);
        wr(12'h004, 32'd123);
        rd(12'h004, r0, r1); chk("R10 value write ignored", r0, v);
        wr(12'h010, 32'h1);
        rd(12'h010, r0, r1); chk("R10 raw write ignored", r0, 0);

        // R12 write beats tick in same cycle
        step();
        tick_en = 1'b1;
        wr(12'h000, 32'd2);
        tick_en = 1'b0;
        rd(12'h004, r0, r1); chk("R12 load wins over tick", r0, 2);

        // R11 alternate variant
        do_reset();
        wr(12'h008, 32'h1);
        wr(12'h008, 32'h0);
        rd(12'h008, r0, r1);
        chk("R11 alt enable sticky", r1, 1);
        chk("R8 std enable cleared", r0, 0);
        wr(12'hF00, 32'h1);
        wr(12'hF04, 32'h3);
        chk("R11 alt test ignored irq", {31'b0, irq1}, 0);
        chk("R11 alt test ignored rst", {31'b0, rq1}, 0);
        rd(12'hF00, r0, r1); chk("R11 alt test control reads zero", r1, 0);
        wr(12'hF00, 32'h0);

        // random phase against the model
        do_reset();
        rnd_tick = 1'b1;
        for (int i = 0; i < 1200; i++) begin
            int op;
            op = $urandom_range(0, 11);
            case (op)
                0, 1: wr(12'h000, $urandom_range(1, 24));
                2:    wr(12'h008, $urandom);
                3, 4: wr(12'h00C, $urandom);
                5:    wr(12'hC00, ($urandom_range(0, 9) < 7) ? 32'h1ACC_E551 : $urandom);
                6:    wr(12'hF00, ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h0);
                7:    wr(12'hF04, $urandom);
                8:    wr(12'h004 + 12'(4 * $urandom_range(0, 4)), $urandom);
                9:    repeat ($urandom_range(1, 8)) step();
                default: begin
                    logic [11:0] a;
                    case ($urandom_range(0, 8))
                        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h008;
                        3: a = 12'h00C; 4: a = 12'h010; 5: a = 12'h014;
                        6: a = 12'hC00; 7: a = 12'hF00; default: a = 12'hF04;
                    endcase
                    step();
                    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
                    step();
                    penable = 1'b1;
                    #1;
                    chk("R10 random read vs model", prdata0, m_read(a));
                    step();
                    psel = 1'b0; penable = 1'b0;
                end
            endcase
        end
        rnd_tick = 1'b0;
        tick_en = 1'b0;
        step();
        finish_run();
    end

endmodule